// File: doc/BRIEF.md
# Coprocessor-0 Exception Entry Controller

This block is the system-control coprocessor of a small in-order, MIPS-style integer core. It holds five architectural registers: Status, Cause, EPC, ErrorEPC and a free-running Count. The core reads them with MFC0 and writes them with MTC0. For each instruction that reaches the execute point, the core presents the instruction word, its PC, whether it sits in a branch delay slot (and, if so, the branch's PC), the MTC0 source operand, and three fault flags. The three flags are signed arithmetic overflow from the ALU, and misaligned load and misaligned store from the address check.

When a synchronous exception is raised, the block does four things:
- It records the exception code in Cause.
- It saves the restart PC in EPC.
- It sets the exception level.
- One cycle later, it issues a fetch redirect to the vector that the boot-exception-vector bit in Status selects.

In the same cycle that the faulting instruction is presented, the block tells the core to suppress that instruction's register writeback. ERET returns through the exception level and the error level rather than popping a status stack, and it has no delay slot. EI and DI set and clear the global enable bit.

Top module: `cp0_exc_ctrl`

## Requirements
- R1: After reset, Status reads 0x0040_0004 (boot-vector bit 22 and error-level bit 2 set), Cause reads 0, and no redirect or read result is pending.
- R2: A COP0 instruction (opcode 0x10) with rs=0x00 reads, and with rs=0x04 writes, the register selected by rd: 9 Count, 12 Status, 13 Cause, 14 EPC, 30 ErrorEPC. The read value appears on rd_data with rd_valid one cycle after issue. Any other rd reads 0.
- R3: Count increments once every two clock cycles. An MTC0 to Count loads the written value, and the first increment after the load comes two cycles later.
- R4: SYSCALL (opcode 0, funct 0x0C) writes ExcCode 8 into Cause[6:2], saves the instruction PC in EPC, sets Status.EXL (bit 1), and raises redirect_valid on the next cycle.
- R5: An arithmetic overflow trap writes ExcCode 12 and raises wb_block in the same cycle the instruction is presented. An instruction with no fault leaves wb_block low.
- R6: A misaligned load writes ExcCode 4 and a misaligned store writes ExcCode 5. When several causes coincide, the priority is load, then store, then overflow, then syscall.
- R7: The redirect target is 0xBFC0_0380 when Status bit 22 is 1, and 0x8000_0180 when it is 0.
- R8: An exception in a branch delay slot sets Cause bit 31 and saves the branch PC in EPC.
- R9: An exception taken while EXL is already set updates ExcCode and redirects, but leaves EPC and Cause bit 31 unchanged.
- R10: ERET (0x4200_0018) behaves as follows. If ERL is set, it clears ERL and redirects to ErrorEPC. Otherwise it clears EXL and redirects to EPC. In both cases the redirect comes on the next cycle.
- R11: EI (0x4200_0038) sets Status bit 16, and DI (0x4200_0039) clears it.
- R12: MTC0 to Cause has no effect. MTC0 to Status changes only bits 0, 1, 2, 16 and 22 (mask 0x0041_0007).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is presented at the execute point this cycle |
| instr | input | 32 | Instruction word |
| instr_pc | input | DATA_W | PC of the presented instruction |
| in_delay_slot | input | 1 | Presented instruction sits in a branch delay slot |
| branch_pc | input | DATA_W | PC of the branch that owns the delay slot |
| rt_value | input | DATA_W | Source operand for MTC0 |
| ovf_trap | input | 1 | Signed overflow on ADD, SUB or ADDI |
| addr_err_load | input | 1 | Misaligned load address |
| addr_err_store | input | 1 | Misaligned store address |
| wb_block | output | 1 | Suppress the presented instruction's register writeback |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | DATA_W | Fetch redirect target |
| rd_valid | output | 1 | MFC0 result valid |
| rd_data | output | DATA_W | MFC0 result |
| exc_level | output | 1 | EXL or ERL is set |

## Verification
A wrong exception level or a wrong vector choice shows up on redirect_pc one cycle after the faulting instruction. A missed redirect pulse shows up in that same cycle. A corrupted EPC, Cause or Status is visible as soon as the next MFC0 returns, one cycle after it is issued. A wrong EPC also surfaces at the ERET redirect. A miscounting Count appears as a wrong difference between two reads a fixed number of cycles apart. A priority or writeback-suppression error shows up as a wrong ExcCode read, or as a wrong wb_block level sampled before the clock edge.

// File: rtl/cp0_pkg.sv
package cp0_pkg;

  // COP0 register numbers (rd field)
  localparam logic [4:0] RN_COUNT    = 5'd9;
  localparam logic [4:0] RN_STATUS   = 5'd12;
  localparam logic [4:0] RN_CAUSE    = 5'd13;
  localparam logic [4:0] RN_EPC      = 5'd14;
  localparam logic [4:0] RN_ERROREPC = 5'd30;

  // Status bit positions
  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_EIE = 16;
  localparam int ST_BEV = 22;

  // Cause layout
  localparam int CA_BD    = 31;
  localparam int CA_CODE0 = 2;

  // Exception codes
  localparam logic [4:0] EXC_ADEL = 5'd4;
  localparam logic [4:0] EXC_ADES = 5'd5;
  localparam logic [4:0] EXC_SYS  = 5'd8;
  localparam logic [4:0] EXC_OV   = 5'd12;

  // Fixed instruction words
  localparam logic [31:0] W_ERET = 32'h4200_0018;
  localparam logic [31:0] W_EI   = 32'h4200_0038;
  localparam logic [31:0] W_DI   = 32'h4200_0039;

  typedef enum logic [2:0] {
    OP_NONE, OP_MFC0, OP_MTC0, OP_ERET, OP_EI, OP_DI, OP_SYS
  } cp0_op_e;

endpackage

// File: rtl/cp0_decode.sv
module cp0_decode
  import cp0_pkg::*;
(
  input  logic        valid,
  input  logic [31:0] instr,
  output cp0_op_e     op,
  output logic [4:0]  reg_idx
);
  logic unused_rt;
  assign unused_rt = ^instr[20:16];
  assign reg_idx   = instr[15:11];

  always_comb begin
    op = OP_NONE;
    if (valid) begin
      if (instr == W_ERET)      op = OP_ERET;
      else if (instr == W_EI)   op = OP_EI;
      else if (instr == W_DI)   op = OP_DI;
      else if (instr[31:26] == 6'h10 && instr[10:0] == 11'd0 && instr[25:21] == 5'h00)
        op = OP_MFC0;
      else if (instr[31:26] == 6'h10 && instr[10:0] == 11'd0 && instr[25:21] == 5'h04)
        op = OP_MTC0;
      else if (instr[31:26] == 6'h00 && instr[5:0] == 6'h0C)
        op = OP_SYS;
    end
  end
endmodule

// File: rtl/cp0_exc_prio.sv
module cp0_exc_prio
  import cp0_pkg::*;
(
  input  logic       valid,
  input  logic       adel,
  input  logic       ades,
  input  logic       ovf,
  input  logic       sys,
  output logic       take,
  output logic [4:0] code
);
  always_comb begin
    take = valid & (adel | ades | ovf | sys);
    if (adel)      code = EXC_ADEL;
    else if (ades) code = EXC_ADES;
    else if (ovf)  code = EXC_OV;
    else           code = EXC_SYS;
  end
endmodule

// File: rtl/cp0_count.sv
module cp0_count #(
  parameter int W   = 32,
  parameter int DIV = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  logic tick;

  generate
    if (DIV > 1) begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] phase;
      always_ff @(posedge clk) begin
        if (rst || load)                  phase <= '0;
        else if (phase == PW'(DIV - 1))   phase <= '0;
        else                              phase <= phase + 1'b1;
      end
      assign tick = (phase == PW'(DIV - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= count + 1'b1;
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (count == $past(count)) || (count == W'($past(count) + 1'b1)));
endmodule

// File: rtl/cp0_exc_ctrl.sv
module cp0_exc_ctrl
  import cp0_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter logic [31:0]     VEC_BOOT  = 32'hBFC0_0380,
  parameter logic [31:0]     VEC_NORM  = 32'h8000_0180,
  parameter int              COUNT_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] instr_pc,
  input  logic              in_delay_slot,
  input  logic [DATA_W-1:0] branch_pc,
  input  logic [DATA_W-1:0] rt_value,
  input  logic              ovf_trap,
  input  logic              addr_err_load,
  input  logic              addr_err_store,
  output logic              wb_block,
  output logic              redirect_valid,
  output logic [DATA_W-1:0] redirect_pc,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              exc_level
);
  localparam logic [DATA_W-1:0] VB = DATA_W'(VEC_BOOT);
  localparam logic [DATA_W-1:0] VN = DATA_W'(VEC_NORM);

  cp0_op_e     op;
  logic [4:0]  reg_idx;
  logic        take;
  logic [4:0]  exc_code;
  logic [DATA_W-1:0] count_q;

  logic st_ie, st_exl, st_erl, st_eie, st_bev;
  logic ca_bd;
  logic [4:0] ca_code;
  logic [DATA_W-1:0] epc_q, errorepc_q;
  logic [DATA_W-1:0] status_word, cause_word, rd_mux;
  logic eret_go, count_load;

  cp0_decode u_dec (
    .valid   (instr_valid),
    .instr   (instr),
    .op      (op),
    .reg_idx (reg_idx)
  );

  cp0_exc_prio u_prio (
    .valid (instr_valid),
    .adel  (addr_err_load),
    .ades  (addr_err_store),
    .ovf   (ovf_trap),
    .sys   (op == OP_SYS),
    .take  (take),
    .code  (exc_code)
  );

  assign count_load = !take && op == OP_MTC0 && reg_idx == RN_COUNT;

  cp0_count #(.W(DATA_W), .DIV(COUNT_DIV)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (count_load),
    .load_val (rt_value),
    .count    (count_q)
  );

  assign wb_block  = take;
  assign eret_go   = !take && op == OP_ERET;
  assign exc_level = st_exl | st_erl;

  always_comb begin
    status_word         = '0;
    status_word[ST_IE]  = st_ie;
    status_word[ST_EXL] = st_exl;
    status_word[ST_ERL] = st_erl;
    status_word[ST_EIE] = st_eie;
    status_word[ST_BEV] = st_bev;
    cause_word                      = '0;
    cause_word[CA_BD]               = ca_bd;
    cause_word[CA_CODE0 +: 5]       = ca_code;
    case (reg_idx)
      RN_COUNT:    rd_mux = count_q;
      RN_STATUS:   rd_mux = status_word;
      RN_CAUSE:    rd_mux = cause_word;
      RN_EPC:      rd_mux = epc_q;
      RN_ERROREPC: rd_mux = errorepc_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_ie <= 1'b0; st_exl <= 1'b0; st_erl <= 1'b1;
      st_eie <= 1'b0; st_bev <= 1'b1;
      ca_bd <= 1'b0; ca_code <= '0;
      epc_q <= '0; errorepc_q <= '0;
      redirect_valid <= 1'b0; redirect_pc <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      redirect_valid <= 1'b0;
      rd_valid       <= 1'b0;
      if (take) begin
        ca_code <= exc_code;
        if (!st_exl) begin
          epc_q <= in_delay_slot ? branch_pc : instr_pc;
          ca_bd <= in_delay_slot;
        end
        st_exl         <= 1'b1;
        redirect_valid <= 1'b1;
        redirect_pc    <= st_bev ? VB : VN;
      end else begin
        case (op)
          OP_MFC0: begin
            rd_valid <= 1'b1;
            rd_data  <= rd_mux;
          end
          OP_MTC0: begin
            case (reg_idx)
              RN_STATUS: begin
                st_ie  <= rt_value[ST_IE];
                st_exl <= rt_value[ST_EXL];
                st_erl <= rt_value[ST_ERL];
                st_eie <= rt_value[ST_EIE];
                st_bev <= rt_value[ST_BEV];
              end
              RN_EPC:      epc_q      <= rt_value;
              RN_ERROREPC: errorepc_q <= rt_value;
              default: ;
            endcase
          end
          OP_ERET: begin
            redirect_valid <= 1'b1;
            if (st_erl) begin
              st_erl      <= 1'b0;
              redirect_pc <= errorepc_q;
            end else begin
              st_exl      <= 1'b0;
              redirect_pc <= epc_q;
            end
          end
          OP_EI: st_eie <= 1'b1;
          OP_DI: st_eie <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // R4
  exc_entry_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> st_exl && redirect_valid);

  // R7
  exc_vector_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (redirect_pc == VB) || (redirect_pc == VN));

  // R9
  epc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (take && st_exl) |=> $stable(epc_q) && $stable(ca_bd));

  // R10
  eret_erl_chk: assert property (@(posedge clk) disable iff (rst)
    (eret_go && st_erl) |=> !st_erl && redirect_valid);

  // R10
  eret_exl_chk: assert property (@(posedge clk) disable iff (rst)
    (eret_go && !st_erl) |=> !st_exl && redirect_valid);

  // R5
  ovf_block_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && ovf_trap) |-> wb_block);

  // R6
  adel_code_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && addr_err_load) |=> ca_code == EXC_ADEL);
endmodule

// File: tb/sim_cp0_exc_ctrl.sv
module sim_cp0_exc_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] instr_pc = '0;
  logic        in_delay_slot = 1'b0;
  logic [31:0] branch_pc = '0;
  logic [31:0] rt_value = '0;
  logic        ovf_trap = 1'b0;
  logic        addr_err_load = 1'b0;
  logic        addr_err_store = 1'b0;
  logic        wb_block, redirect_valid, rd_valid, exc_level;
  logic [31:0] redirect_pc, rd_data;

  int compared = 0;
  int mismatched = 0;
  logic last_wb;
  logic [31:0] rv;
  bit finished = 0;

  localparam logic [31:0] NOP  = 32'h0;
  localparam logic [31:0] SYSC = 32'h0000_000C;
  localparam logic [31:0] ERET = 32'h4200_0018;
  localparam logic [31:0] EI   = 32'h4200_0038;
  localparam logic [31:0] DI   = 32'h4200_0039;
  localparam logic [31:0] VBOOT = 32'hBFC0_0380;
  localparam logic [31:0] VNORM = 32'h8000_0180;

  always #2 clk = ~clk;

  cp0_exc_ctrl u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .instr_pc(instr_pc), .in_delay_slot(in_delay_slot), .branch_pc(branch_pc),
    .rt_value(rt_value), .ovf_trap(ovf_trap), .addr_err_load(addr_err_load),
    .addr_err_store(addr_err_store), .wb_block(wb_block),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .rd_valid(rd_valid), .rd_data(rd_data), .exc_level(exc_level)
  );

  function automatic logic [31:0] w_mfc0(input logic [4:0] rd);
    return {6'h10, 5'h00, 5'd0, rd, 11'd0};
  endfunction
  function automatic logic [31:0] w_mtc0(input logic [4:0] rd);
    return {6'h10, 5'h04, 5'd0, rd, 11'd0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle; called at a negedge, returns at the next negedge
  // flt = {adel, ades, ovf}
  task automatic issue(input logic [31:0] ins, input logic [31:0] pc,
                       input logic [2:0] flt, input logic [31:0] wd, input logic ds);
    instr_valid = 1'b1; instr = ins; instr_pc = pc;
    addr_err_load = flt[2]; addr_err_store = flt[1]; ovf_trap = flt[0];
    rt_value = wd; in_delay_slot = ds; branch_pc = pc - 32'd4;
    #1 last_wb = wb_block;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0; instr = '0; addr_err_load = 0; addr_err_store = 0;
    ovf_trap = 0; in_delay_slot = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] r);
    issue(w_mfc0(r), 32'h0, 3'b000, 32'h0, 1'b0);
    rv = rd_data;
  endtask

  task automatic wr(input logic [4:0] r, input logic [31:0] v);
    issue(w_mtc0(r), 32'h0, 3'b000, v, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 redirect idle", {31'd0, redirect_valid}, 32'd0);
    check("R1 rd_valid idle", {31'd0, rd_valid}, 32'd0);
    rd(5'd12); check("R1 Status", rv, 32'h0040_0004);
    rd(5'd13); check("R1 Cause", rv, 32'h0);
  endtask

  task automatic t_enable;
    issue(EI, 32'h0, 3'b000, 32'h0, 1'b0);
    rd(5'd12); check("R11 EI", rv, 32'h0041_0004);
    issue(DI, 32'h0, 3'b000, 32'h0, 1'b0);
    rd(5'd12); check("R11 DI", rv, 32'h0040_0004);
  endtask

  task automatic t_mask;
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13); check("R12 Cause write ignored", rv, 32'h0);
    wr(5'd12, 32'hFFFF_FFFF);
    rd(5'd12); check("R12 Status mask", rv, 32'h0041_0007);
    wr(5'd12, 32'h0000_0004);
    rd(5'd12); check("R12 Status restore", rv, 32'h0000_0004);
  endtask

  task automatic t_regs;
    wr(5'd14, 32'hA5A5_0010);
    rd(5'd14); check("R2 EPC rw", rv, 32'hA5A5_0010);
    check("R2 rd_valid", {31'd0, rd_valid}, 32'd1);
    wr(5'd30, 32'h1234_0000);
    rd(5'd30); check("R2 ErrorEPC rw", rv, 32'h1234_0000);
    rd(5'd5);  check("R2 unmodelled reads 0", rv, 32'h0);
  endtask

  task automatic t_count;
    wr(5'd9, 32'd100);
    rd(5'd9); check("R3 Count loaded", rv, 32'd100);
    idle(3);
    rd(5'd9); check("R3 Count half rate", rv, 32'd102);
  endtask

  task automatic t_syscall;
    issue(SYSC, 32'h0000_1000, 3'b000, 32'h0, 1'b0);
    check("R4 redirect pulse", {31'd0, redirect_valid}, 32'd1);
    check("R7 BEV=0 vector", redirect_pc, VNORM);
    check("R4 wb_block", {31'd0, last_wb}, 32'd1);
    rd(5'd13); check("R4 Cause Sys", rv, 32'h0000_0020);
    check("R4 redirect one cycle", {31'd0, redirect_valid}, 32'd0);
    rd(5'd14); check("R4 EPC", rv, 32'h0000_1000);
    rd(5'd12); check("R4 EXL set", rv, 32'h0000_0006);
  endtask

  task automatic t_eret;
    issue(ERET, 32'h0, 3'b000, 32'h0, 1'b0);
    check("R10 ERL eret redirect", {31'd0, redirect_valid}, 32'd1);
    check("R10 ErrorEPC target", redirect_pc, 32'h1234_0000);
    rd(5'd12); check("R10 ERL cleared", rv, 32'h0000_0002);
    issue(ERET, 32'h0, 3'b000, 32'h0, 1'b0);
    check("R10 EPC target", redirect_pc, 32'h0000_1000);
    rd(5'd12); check("R10 EXL cleared", rv, 32'h0);
  endtask

  task automatic t_ovf;
    issue(NOP, 32'h0000_1100, 3'b000, 32'h0, 1'b0);
    check("R5 no fault no block", {31'd0, last_wb}, 32'd0);
    check("R5 no fault no redirect", {31'd0, redirect_valid}, 32'd0);
    issue(NOP, 32'h0000_1100, 3'b001, 32'h0, 1'b0);
    check("R5 wb_block", {31'd0, last_wb}, 32'd1);
    check("R5 redirect", redirect_pc, VNORM);
    rd(5'd13); check("R5 Cause Ov", rv, 32'h0000_0030);
    rd(5'd14); check("R5 EPC", rv, 32'h0000_1100);
  endtask

  task automatic t_nested;
    issue(NOP, 32'h0000_2000, 3'b100, 32'h0, 1'b0);
    check("R9 still redirects", redirect_pc, VNORM);
    rd(5'd13); check("R9 code updates", rv, 32'h0000_0010);
    rd(5'd14); check("R9 EPC held", rv, 32'h0000_1100);
    issue(ERET, 32'h0, 3'b000, 32'h0, 1'b0);
    check("R9 eret to held EPC", redirect_pc, 32'h0000_1100);
  endtask

  task automatic t_prio;
    issue(NOP, 32'h0000_2100, 3'b111, 32'h0, 1'b0);
    rd(5'd13); check("R6 AdEL first", rv, 32'h0000_0010);
    issue(ERET, 32'h0, 3'b000, 32'h0, 1'b0);
    issue(NOP, 32'h0000_2200, 3'b011, 32'h0, 1'b0);
    rd(5'd13); check("R6 AdES over Ov", rv, 32'h0000_0014);
    issue(ERET, 32'h0, 3'b000, 32'h0, 1'b0);
    issue(SYSC, 32'h0000_2300, 3'b001, 32'h0, 1'b0);
    rd(5'd13); check("R6 Ov over Sys", rv, 32'h0000_0030);
    issue(ERET, 32'h0, 3'b000, 32'h0, 1'b0);
    rd(5'd12); check("R6 level back to 0", rv, 32'h0);
  endtask

  task automatic t_delay;
    wr(5'd12, 32'h0040_0000);
    issue(SYSC, 32'h0000_3004, 3'b000, 32'h0, 1'b1);
    check("R7 BEV=1 vector", redirect_pc, VBOOT);
    rd(5'd14); check("R8 EPC branch pc", rv, 32'h0000_3000);
    rd(5'd13); check("R8 BD set", rv, 32'h8000_0020);
    check("R8 level out", {31'd0, exc_level}, 32'd1);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    t_reset;
    t_enable;
    t_mask;
    t_regs;
    t_count;
    t_syscall;
    t_eret;
    t_ovf;
    t_nested;
    t_prio;
    t_delay;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule